// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter and one output pin. Both advance only in system clock cycles where the count-clock enable is high. A load strobe captures a reload value and a 3-bit mode, and the channel starts over. The mode decides three things: whether the gate input acts as a level enable or as a rising-edge trigger, whether the counter steps by one or by two, and how the output pin behaves around terminal count.

Six behaviours are supported. Modes 0 and 1 are terminal-count interrupt and triggered one-shot. Mode 2 is a rate generator and mode 3 is a square wave. Modes 4 and 5 are software strobe and gate strobe. Mode codes 6 and 7 alias to 2 and 3. A reload value of zero stands for 65536 count steps. Counting is binary only. The enclosing timer uses the live count output to latch a readback value and routes the output pin to an interrupt or speaker line.

Top module: `pitCounterCore`

## Requirements
- R1: After reset the count is 0, the output pin is high and the mode is 0 with counting stopped. Nothing changes until the first load, whatever the state of the count enable.
- R2: A load strobe takes effect at the next clock edge and sets count to the new value N. In mode 3 the count is instead set to N+1 when N is odd. Mode code 6 behaves as mode 2 and code 7 as mode 3. A load wins over a gate rising edge in the same cycle, and that edge is discarded.
- R3: Mode 0: the load drives the pin low. Each enabled step decrements the count by one. The pin goes high in the step that brings the count to 0 and stays high while the count wraps through 65535, until the next load.
- R4: Mode 4: the pin is high after the load. It is low for exactly the one step in which the count becomes 0, and high in every other step.
- R5: In modes 0, 2, 3 and 4 a low gate freezes count and pin. In modes 0 and 4 a gate rising edge does not reload the count.
- R6: Mode 1: after the load the count holds N and the pin stays high until a gate rising edge. That edge reloads N and drives the pin low. Counting then ignores the gate level, and the pin goes high when the count reaches 0 and stays high.
- R7: Mode 5: counting waits for a gate rising edge, which reloads N. The pin is low for the one step in which the count becomes 0. A new rising edge while counting restarts from N.
- R8: Mode 2: the count runs N, N-1, … 1 and then reloads N, so the period is N steps. The pin is low exactly while the count is 1.
- R9: Mode 3: the count drops by two per step and stays even. At each half boundary the pin toggles and the count reloads. For odd N the high half lasts (N+1)/2 steps and the low half (N-1)/2 steps.
- R10: In modes 2 and 3 a gate rising edge reloads the count as at load time and forces the pin high.
- R11: A reload value of 0 counts 65536 steps before terminal count. In mode 4 the pin goes low on the 65536th enabled step after the load.
- R12: In a cycle with the count enable low, no load and no gate rising edge, count and pin hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Count-clock enable, one step per high cycle |
| gate | input | 1 | Gate level / trigger input |
| loadStb | input | 1 | Load strobe for reload value and mode |
| loadMode | input | 3 | Operating mode captured on load |
| loadVal | input | 16 | Reload value captured on load (0 means 65536) |
| count | output | 16 | Current counter value |
| outPin | output | 1 | Mode-dependent output |

## Verification
The assertions assume a few things about the inputs. In modes 2 and 3 the reload value is never 1, because a one-step period has no defined pulse or half-period. The gate edge is taken as seen by this block's own edge detector, sampled at the system clock. The stimulus keeps every reload in modes 2, 3, 6 and 7 at 2 or above. It changes gate, enable and strobes only between edges, so the reference model and the design sample the same values.

// File: rtl/pitCorePkg.sv
package pitCorePkg;

  typedef enum logic [2:0] {
    MODE_TC_INT    = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } cntMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeNew;   // capture reload value from the port
    logic reload;    // reload count from stored value
    logic useHalf;   // reload with odd-value half-period rounding
    logic highHalf;  // rounding direction: high half gets +1
    logic dec1;      // step by one
    logic dec2;      // step by two
  } dpCtrl_t;

  function automatic cntMode_e normMode(input logic [2:0] raw);
    if (raw[2] && raw[1]) return cntMode_e'({1'b0, raw[1:0]});
    return cntMode_e'(raw);
  endfunction

endpackage

// File: rtl/pitGateEdge.sv
module pitGateEdge (
  input  logic clk,
  input  logic rstN,
  input  logic gate,
  output logic gateRise
);
  logic gatePrev;

  always_ff @(posedge clk) begin
    if (!rstN) gatePrev <= 1'b0;
    else       gatePrev <= gate;
  end

  assign gateRise = gate & ~gatePrev;
endmodule

// File: rtl/pitCounterDp.sv
module pitCounterDp
  import pitCorePkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      ctl,
  input  logic [W-1:0] newVal,
  output logic [W-1:0] cntQ,
  output logic         cntIsOne,
  output logic         cntIsTwo
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] reloadQ;
  logic [W-1:0] srcVal;
  logic [W-1:0] halfVal;
  logic [W-1:0] startVal;

  assign srcVal   = ctl.takeNew ? newVal : reloadQ;
  assign halfVal  = srcVal[0] ? (ctl.highHalf ? srcVal + ONE : srcVal - ONE) : srcVal;
  assign startVal = ctl.useHalf ? halfVal : srcVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
      cntQ    <= '0;
    end else begin
      if (ctl.takeNew) reloadQ <= newVal;
      if (ctl.takeNew || ctl.reload) cntQ <= startVal;
      else if (ctl.dec1)             cntQ <= cntQ - ONE;
      else if (ctl.dec2)             cntQ <= cntQ - TWO;
    end
  end

  assign cntIsOne = (cntQ == ONE);
  assign cntIsTwo = (cntQ == TWO);
endmodule

// File: rtl/pitCounterCtrl.sv
module pitCounterCtrl
  import pitCorePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntEn,
  input  logic       gate,
  input  logic       gateRise,
  input  logic       loadStb,
  input  logic [2:0] loadMode,
  input  logic       cntIsOne,
  input  logic       cntIsTwo,
  output dpCtrl_t    ctl,
  output logic       outPin
);
  cntMode_e modeQ, modeD;
  logic     runQ, runD;
  logic     outQ, outD;
  logic     levelGated;
  logic     edgeTrig;
  logic     stepOk;

  always_comb begin
    levelGated = (modeQ == MODE_TC_INT) || (modeQ == MODE_RATE) ||
                 (modeQ == MODE_SQUARE) || (modeQ == MODE_SW_STROBE);
    edgeTrig   = (modeQ == MODE_ONESHOT) || (modeQ == MODE_RATE) ||
                 (modeQ == MODE_SQUARE) || (modeQ == MODE_HW_STROBE);
    stepOk     = cntEn && runQ && (gate || !levelGated);
  end

  always_comb begin
    ctl   = '0;
    modeD = modeQ;
    runD  = runQ;
    outD  = outQ;
    if (loadStb) begin
      modeD        = normMode(loadMode);
      ctl.takeNew  = 1'b1;
      ctl.useHalf  = (modeD == MODE_SQUARE);
      ctl.highHalf = 1'b1;
      outD         = (modeD != MODE_TC_INT);
      runD         = !((modeD == MODE_ONESHOT) || (modeD == MODE_HW_STROBE));
    end else if (gateRise && edgeTrig) begin
      ctl.reload   = 1'b1;
      ctl.useHalf  = (modeQ == MODE_SQUARE);
      ctl.highHalf = 1'b1;
      outD         = (modeQ != MODE_ONESHOT);
      runD         = 1'b1;
    end else if (stepOk) begin
      case (modeQ)
        MODE_TC_INT, MODE_ONESHOT: begin
          ctl.dec1 = 1'b1;
          if (cntIsOne) outD = 1'b1;
        end
        MODE_SW_STROBE, MODE_HW_STROBE: begin
          ctl.dec1 = 1'b1;
          outD     = !cntIsOne;
        end
        MODE_RATE: begin
          if (cntIsOne) begin
            ctl.reload = 1'b1;
            outD       = 1'b1;
          end else begin
            ctl.dec1 = 1'b1;
            outD     = !cntIsTwo;
          end
        end
        MODE_SQUARE: begin
          if (cntIsTwo) begin
            ctl.reload   = 1'b1;
            ctl.useHalf  = 1'b1;
            ctl.highHalf = !outQ;
            outD         = !outQ;
          end else begin
            ctl.dec2 = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_TC_INT;
      runQ  <= 1'b0;
      outQ  <= 1'b1;
    end else begin
      modeQ <= modeD;
      runQ  <= runD;
      outQ  <= outD;
    end
  end

  assign outPin = outQ;
endmodule

// File: rtl/pitCounterCore.sv
module pitCounterCore
  import pitCorePkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntEn,
  input  logic         gate,
  input  logic         loadStb,
  input  logic [2:0]   loadMode,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         outPin
);
  dpCtrl_t ctl;
  logic    gateRise;
  logic    cntIsOne;
  logic    cntIsTwo;

  pitGateEdge uEdge (
    .clk      (clk),
    .rstN     (rstN),
    .gate     (gate),
    .gateRise (gateRise)
  );

  pitCounterCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cntEn    (cntEn),
    .gate     (gate),
    .gateRise (gateRise),
    .loadStb  (loadStb),
    .loadMode (loadMode),
    .cntIsOne (cntIsOne),
    .cntIsTwo (cntIsTwo),
    .ctl      (ctl),
    .outPin   (outPin)
  );

  pitCounterDp #(.W(W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .newVal   (loadVal),
    .cntQ     (count),
    .cntIsOne (cntIsOne),
    .cntIsTwo (cntIsTwo)
  );
endmodule

// File: rtl/pitCounterCoreChk.sv
module pitCounterCoreChk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         cntEn,
  input logic         gate,
  input logic         loadStb,
  input logic [2:0]   loadMode,
  input logic [W-1:0] loadVal,
  input logic [W-1:0] count,
  input logic         outPin
);
  logic [2:0] curMode;
  logic       gPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode <= 3'd0;
      gPrev   <= 1'b0;
    end else begin
      gPrev <= gate;
      if (loadStb) curMode <= (loadMode[2] && loadMode[1]) ? {1'b0, loadMode[1:0]} : loadMode;
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && loadMode[1:0] != 2'd3) |=> (count == $past(loadVal))); // R2

  AST_M0_LOAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && loadMode == 3'd0) |=> !outPin); // R3

  AST_M1_TRIG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd1 && gate && !gPrev && !loadStb) |=> !outPin); // R6

  AST_M2_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd2) |-> (outPin == (count != W'(1)))); // R8

  AST_M3_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd3) |-> !count[0]); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !loadStb && !gate) |=> ($stable(count) && $stable(outPin))); // R12
endmodule

bind pitCounterCore pitCounterCoreChk #(.W(W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cntEn    (cntEn),
  .gate     (gate),
  .loadStb  (loadStb),
  .loadMode (loadMode),
  .loadVal  (loadVal),
  .count    (count),
  .outPin   (outPin)
);

// File: tb/tb_pitCounterCore.sv
module tb_pitCounterCore;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic        gate = 1'b0;
  logic        loadStb = 1'b0;
  logic [2:0]  loadMode = 3'd0;
  logic [15:0] loadVal = 16'd0;
  logic [15:0] count;
  logic        outPin;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // reference model state
  int mCnt = 0, mN = 0, mMode = 0;
  bit mOut = 1'b1, mRun = 1'b0, mGp = 1'b0;

  pitCounterCore dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .gate(gate), .loadStb(loadStb),
    .loadMode(loadMode), .loadVal(loadVal), .count(count), .outPin(outPin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic int halfStart(int hi);
    if (mN % 2 == 1) return hi ? ((mN + 1) & 16'hffff) : (mN - 1);
    return mN;
  endfunction

  function automatic string tagFor(int m);
    case (m)
      0: return "R3";
      1: return "R6";
      2: return "R8";
      3: return "R9";
      4: return "R4";
      default: return "R7";
    endcase
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mCnt = 0; mN = 0; mMode = 0; mOut = 1; mRun = 0; mGp = 0;
    end else begin
      bit rise;
      rise = gate && !mGp;
      mGp  = gate;
      if (loadStb) begin
        mN    = int'(loadVal);
        mMode = (loadMode >= 6) ? int'(loadMode) - 4 : int'(loadMode);
        mRun  = !(mMode == 1 || mMode == 5);
        mOut  = (mMode != 0);
        mCnt  = (mMode == 3) ? halfStart(1) : mN;
      end else if (rise && (mMode == 1 || mMode == 2 || mMode == 3 || mMode == 5)) begin
        mRun = 1;
        mOut = (mMode != 1);
        mCnt = (mMode == 3) ? halfStart(1) : mN;
      end else if (cntEn && mRun && (gate || mMode == 1 || mMode == 5)) begin
        case (mMode)
          0, 1: begin
            mCnt = (mCnt + 65535) % 65536;
            if (mCnt == 0) mOut = 1;
          end
          4, 5: begin
            mCnt = (mCnt + 65535) % 65536;
            mOut = (mCnt != 0);
          end
          2: begin
            if (mCnt == 1) begin mCnt = mN; mOut = 1; end
            else begin mCnt = (mCnt + 65535) % 65536; mOut = (mCnt != 1); end
          end
          default: begin
            if (mCnt == 2) begin mOut = !mOut; mCnt = halfStart(mOut); end
            else mCnt = (mCnt + 65534) % 65536;
          end
        endcase
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(tagFor(mMode), int'(count), mCnt);
      check(tagFor(mMode), int'(outPin), int'(mOut));
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoad(int m, int n);
    @(negedge clk);
    loadStb = 1; loadMode = 3'(m); loadVal = 16'(n);
    @(negedge clk);
    loadStb = 0;
  endtask

  initial begin
    int held;
    int steps;
    tick(3);
    check("R1", int'(count), 0);
    check("R1", int'(outPin), 1);
    rstN = 1;
    cntEn = 1; gate = 1;
    tick(5);
    check("R1", int'(count), 0);
    check("R1", int'(outPin), 1);

    // mode 0
    doLoad(0, 5);
    check("R2", int'(count), 5);
    check("R3", int'(outPin), 0);
    tick(8);
    check("R3", int'(outPin), 1);
    gate = 0; held = int'(count);
    tick(4);
    check("R5", int'(count), held);
    gate = 1;
    tick(1);
    check("R5", int'(count), (held + 65535) % 65536);

    // mode 4 with gappy enable
    doLoad(4, 3);
    check("R4", int'(outPin), 1);
    cntEn = 0; held = int'(count);
    tick(3);
    check("R12", int'(count), held);
    for (int i = 0; i < 12; i++) begin cntEn = (i % 2 == 0); tick(1); end
    cntEn = 1;

    // mode 1, gate trigger
    gate = 0;
    doLoad(1, 4);
    tick(3);
    check("R6", int'(count), 4);
    check("R6", int'(outPin), 1);
    gate = 1; tick(1);
    check("R6", int'(outPin), 0);
    tick(2); gate = 0; tick(6);
    check("R6", int'(outPin), 1);

    // mode 5, trigger and retrigger
    doLoad(5, 6);
    gate = 1; tick(3); gate = 0; tick(1); gate = 1; tick(1);
    check("R7", int'(count), 6);
    tick(10);

    // mode 6 aliases rate generator
    doLoad(6, 4);
    tick(9);
    gate = 0; tick(1); gate = 1; tick(1);
    check("R10", int'(count), 4);
    check("R10", int'(outPin), 1);
    tick(8);

    // mode 7 aliases square, odd count
    doLoad(7, 5);
    check("R2", int'(count), 6);
    tick(20);
    doLoad(3, 6);
    tick(7);
    gate = 0; tick(1); gate = 1; tick(1);
    check("R10", int'(count), 6);
    check("R10", int'(outPin), 1);
    tick(10);

    // load and gate edge in the same cycle: edge discarded
    gate = 0; tick(1);
    @(negedge clk);
    loadStb = 1; loadMode = 3'd1; loadVal = 16'd7; gate = 1;
    @(negedge clk);
    loadStb = 0;
    tick(3);
    check("R2", int'(count), 7);
    check("R2", int'(outPin), 1);

    // zero reload means 65536 steps
    doLoad(4, 0);
    steps = 0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      steps++;
      if (!outPin) break;
    end
    check("R11", steps, 65536);

    // mixed tail
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cntEn = ($urandom % 4) != 0;
      if ($urandom % 9 == 0) gate = !gate;
      if ($urandom % 60 == 0) begin
        loadStb = 1; loadMode = 3'($urandom % 8); loadVal = 16'(2 + $urandom % 40);
      end else loadStb = 0;
    end
    loadStb = 0;
    tick(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule